// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the memory-side steps an 8-bit CPU core needs when it takes a hardware interrupt, when it executes a break instruction, and when it returns from either one. On entry it saves the flags byte and the two bytes of the program counter on a downward-growing stack. It then fetches a 16-bit handler address from a vector table and hands the core a new program counter and stack pointer. It also clears the interrupt-enable flag. On return it pops the three bytes in reverse order and restores the program counter, the flags byte (which carries the saved interrupt-enable bit) and the stack pointer.

Every stack access and every vector fetch goes through one request/acknowledge memory port, so memory latency can be anything from zero wait cycles upward. A small context tracker records whether each open context came from a break or from a hardware interrupt. It raises a misuse pulse when a hardware-interrupt return closes a context that a break opened. The core sees a busy output for the whole operation. Strobes that arrive while the block is busy are dropped.

Top module: `intr_seq_top`

## Requirements
- R1: After reset, busy_o, mem_req_o, pc_load_o, sp_load_o, psw_load_o, ie_clr_o and misuse_o are all 0.
- R2: An entry writes three bytes in this order: the flags byte at SP-1, then PC[15:8] at SP-2, then PC[7:0] at SP-3, where SP, PC and flags are the values of sp_i, pc_i and psw_i in the cycle the strobe is accepted.
- R3: After the pushes, an entry reads the low handler byte at the vector address and then the high byte at the vector address with bit 0 set. A break uses the fixed address BRK_VEC (default 0x003E). A hardware interrupt uses ack_vec_i.
- R4: An entry completes with a one-cycle pulse of pc_load_o, sp_load_o and ie_clr_o, with pc_new_o = {high byte, low byte} and sp_new_o = SP-3. A break does this whatever the interrupt-enable bit in psw_i holds.
- R5: A return reads PC[7:0] at SP, PC[15:8] at SP+1 and the flags byte at SP+2. It then pulses pc_load_o, sp_load_o and psw_load_o for one cycle with the restored values and sp_new_o = SP+3. ie_clr_o stays 0.
- R6: Both retb_i and reti_i start the same pop sequence. A return from break over a hardware context raises no misuse.
- R7: misuse_o pulses for exactly the first busy cycle of a return that reti_i started while the innermost tracked context came from a break. It stays 0 for every other operation.
- R8: The request holds its address, direction and data until mem_ack_i. Each byte step advances only on an acknowledge.
- R9: brk_i, ack_i, retb_i and reti_i are ignored while busy_o is 1. Changes on psw_i, pc_i and sp_i during that time do not affect the operation in progress.
- R10: When several strobes arrive together while idle, exactly one operation starts, chosen in the order brk_i, ack_i, retb_i, reti_i.
- R11: The tracker keeps up to NEST_DEPTH contexts. An entry beyond that drops the outermost context. A return with no tracked context raises no misuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_i | input | 1 | Break instruction strobe |
| ack_i | input | 1 | Hardware interrupt accept strobe |
| ack_vec_i | input | AW | Vector table address for the accepted interrupt |
| retb_i | input | 1 | Return-from-break strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| psw_i | input | DW | Current flags byte |
| pc_i | input | AW | Current program counter |
| sp_i | input | AW | Current stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Memory acknowledge; completes the request |
| mem_rdata_i | input | DW | Read data, valid with mem_ack_i |
| busy_o | output | 1 | Operation in progress |
| pc_load_o | output | 1 | Load pc_new_o into the PC |
| pc_new_o | output | AW | New program counter |
| sp_load_o | output | 1 | Load sp_new_o into the SP |
| sp_new_o | output | AW | New stack pointer |
| psw_load_o | output | 1 | Load psw_new_o into the flags register |
| psw_new_o | output | DW | Restored flags byte |
| ie_clr_o | output | 1 | Clear the interrupt-enable flag |
| misuse_o | output | 1 | Hardware return closed a break context |

## Verification
The bench builds the block with NEST_DEPTH set to 2 and leaves AW, DW and BRK_VEC at their defaults. A depth of 2 means three nested entries overflow the tracker, so the dropped-context rule and the empty-tracker return can both be reached. The memory model's wait count is changed between operations (0, 1 and 2 cycles), so each byte step is seen with an immediate acknowledge and with a held request. Nested break and hardware contexts, simultaneous strobes, and strobes plus input changes during a busy operation are each driven at least once.

// File: rtl/intr_seq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package intr_seq_pkg;

    // Sequencer steps; each memory step waits for one acknowledge.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PSW,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_POP_PCL,
        ST_POP_PCH,
        ST_POP_PSW,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/intr_seq_arb.sv
// Start arbiter: picks at most one operation from the incoming strobes.
// Assumes the strobes are single-cycle and are only honoured while idle.
// Fixed order: break, hardware accept, return-from-break, hardware return.
module intr_seq_arb (
    input  logic idle_i,
    input  logic brk_i,
    input  logic ack_i,
    input  logic retb_i,
    input  logic reti_i,
    output logic go_entry_o,
    output logic go_brk_o,
    output logic go_return_o,
    output logic go_reti_o
);

    logic go_hw;

    // Priority decode, gated by idle so busy-time strobes are dropped.
    always_comb begin
        go_brk_o    = idle_i & brk_i;
        go_hw       = idle_i & ~brk_i & ack_i;
        go_entry_o  = go_brk_o | go_hw;
        go_return_o = idle_i & ~brk_i & ~ack_i & (retb_i | reti_i);
        go_reti_o   = go_return_o & ~retb_i;
    end

endmodule

// File: rtl/intr_seq_fsm.sv
// Byte sequencer: pushes flags and PC, fetches the vector, or pops the
// saved context, all over one request/acknowledge memory port.
// Assumes AW == 2*DW (PC is two bytes) and a downward-growing stack.
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_entry_i,
    input  logic          go_return_i,
    input  logic [AW-1:0] vec_i,
    input  logic [DW-1:0] psw_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] sp_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          idle_o,
    output logic          busy_o,
    output logic          pc_load_o,
    output logic [AW-1:0] pc_new_o,
    output logic          sp_load_o,
    output logic [AW-1:0] sp_new_o,
    output logic          psw_load_o,
    output logic [DW-1:0] psw_new_o,
    output logic          ie_clr_o
);

    localparam logic [AW-1:0] ONE   = AW'(1);
    localparam logic [AW-1:0] TWO   = AW'(2);
    localparam logic [AW-1:0] THREE = AW'(3);

    seq_state_e    state_q;
    logic [DW-1:0] psw_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] vec_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] rd_psw_q;
    logic          ret_q;
    logic          done;

    // State advance and capture of operands and read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            psw_q    <= '0;
            pc_q     <= '0;
            sp_q     <= '0;
            vec_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            rd_psw_q <= '0;
            ret_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go_entry_i) begin
                        psw_q   <= psw_i;
                        pc_q    <= pc_i;
                        sp_q    <= sp_i;
                        vec_q   <= vec_i;
                        ret_q   <= 1'b0;
                        state_q <= ST_PUSH_PSW;
                    end else if (go_return_i) begin
                        sp_q    <= sp_i;
                        ret_q   <= 1'b1;
                        state_q <= ST_POP_PCL;
                    end
                end
                ST_PUSH_PSW: if (mem_ack_i) state_q <= ST_PUSH_PCH;
                ST_PUSH_PCH: if (mem_ack_i) state_q <= ST_PUSH_PCL;
                ST_PUSH_PCL: if (mem_ack_i) state_q <= ST_VEC_LO;
                ST_VEC_LO: if (mem_ack_i) begin
                    lo_q    <= mem_rdata_i;
                    state_q <= ST_VEC_HI;
                end
                ST_VEC_HI: if (mem_ack_i) begin
                    hi_q    <= mem_rdata_i;
                    state_q <= ST_DONE;
                end
                ST_POP_PCL: if (mem_ack_i) begin
                    lo_q    <= mem_rdata_i;
                    state_q <= ST_POP_PCH;
                end
                ST_POP_PCH: if (mem_ack_i) begin
                    hi_q    <= mem_rdata_i;
                    state_q <= ST_POP_PSW;
                end
                ST_POP_PSW: if (mem_ack_i) begin
                    rd_psw_q <= mem_rdata_i;
                    state_q  <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory request address, direction and data for the current step.
    always_comb begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (state_q)
            ST_PUSH_PSW: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - ONE;
                mem_wdata_o = psw_q;
            end
            ST_PUSH_PCH: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - TWO;
                mem_wdata_o = pc_q[AW-1:DW];
            end
            ST_PUSH_PCL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - THREE;
                mem_wdata_o = pc_q[DW-1:0];
            end
            ST_VEC_LO:  mem_addr_o = vec_q;
            ST_VEC_HI:  mem_addr_o = vec_q | ONE;
            ST_POP_PCL: mem_addr_o = sp_q;
            ST_POP_PCH: mem_addr_o = sp_q + ONE;
            ST_POP_PSW: mem_addr_o = sp_q + TWO;
            default:    mem_req_o  = 1'b0;
        endcase
    end

    // Completion strobes and result values toward the core.
    always_comb begin
        done       = (state_q == ST_DONE);
        idle_o     = (state_q == ST_IDLE);
        busy_o     = ~idle_o;
        pc_load_o  = done;
        sp_load_o  = done;
        psw_load_o = done & ret_q;
        ie_clr_o   = done & ~ret_q;
        pc_new_o   = {hi_q, lo_q};
        sp_new_o   = ret_q ? (sp_q + THREE) : (sp_q - THREE);
        psw_new_o  = rd_psw_q;
    end

endmodule

// File: rtl/intr_seq_ctx.sv
// Context tracker: a shift stack of "opened by break" bits, one per
// nested context, plus the registered misuse pulse.
// Assumes push and pop never occur in the same cycle.
module intr_seq_ctx #(
    parameter int NEST_DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic push_brk_i,
    input  logic pop_i,
    input  logic pop_reti_i,
    output logic misuse_o
);

    localparam int CW = $clog2(NEST_DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(NEST_DEPTH);

    logic [NEST_DEPTH-1:0] kinds_q;
    logic [NEST_DEPTH-1:0] kinds_push;
    logic [CW-1:0]         cnt_q;
    logic                  top_brk;

    // Next stack image on push; bit 0 is the innermost context.
    always_comb begin
        kinds_push    = kinds_q << 1;
        kinds_push[0] = push_brk_i;
        top_brk       = (cnt_q != '0) & kinds_q[0];
    end

    // Stack update, depth count and misuse flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kinds_q  <= '0;
            cnt_q    <= '0;
            misuse_o <= 1'b0;
        end else begin
            misuse_o <= pop_i & pop_reti_i & top_brk;
            if (push_i) begin
                kinds_q <= kinds_push;
                if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
            end else if (pop_i) begin
                kinds_q <= kinds_q >> 1;
                if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
            end
        end
    end

endmodule

// File: rtl/intr_seq_top.sv
// Interrupt entry and return sequencer top: arbiter, byte sequencer and
// context tracker. Assumes AW == 2*DW and a BRK_VEC that is even.
module intr_seq_top #(
    parameter int              AW         = 16,
    parameter int              DW         = 8,
    parameter int              NEST_DEPTH = 4,
    parameter logic [AW-1:0]   BRK_VEC    = 16'h003E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          brk_i,
    input  logic          ack_i,
    input  logic [AW-1:0] ack_vec_i,
    input  logic          retb_i,
    input  logic          reti_i,
    input  logic [DW-1:0] psw_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] sp_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          pc_load_o,
    output logic [AW-1:0] pc_new_o,
    output logic          sp_load_o,
    output logic [AW-1:0] sp_new_o,
    output logic          psw_load_o,
    output logic [DW-1:0] psw_new_o,
    output logic          ie_clr_o,
    output logic          misuse_o
);

    logic          idle;
    logic          go_entry;
    logic          go_brk;
    logic          go_return;
    logic          go_reti;
    logic [AW-1:0] vec_sel;

    // Vector address: fixed pair for break, supplied one otherwise.
    always_comb vec_sel = go_brk ? BRK_VEC : ack_vec_i;

    intr_seq_arb u_arb (
        .idle_i      (idle),
        .brk_i       (brk_i),
        .ack_i       (ack_i),
        .retb_i      (retb_i),
        .reti_i      (reti_i),
        .go_entry_o  (go_entry),
        .go_brk_o    (go_brk),
        .go_return_o (go_return),
        .go_reti_o   (go_reti)
    );

    intr_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_entry_i  (go_entry),
        .go_return_i (go_return),
        .vec_i       (vec_sel),
        .psw_i       (psw_i),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .idle_o      (idle),
        .busy_o      (busy_o),
        .pc_load_o   (pc_load_o),
        .pc_new_o    (pc_new_o),
        .sp_load_o   (sp_load_o),
        .sp_new_o    (sp_new_o),
        .psw_load_o  (psw_load_o),
        .psw_new_o   (psw_new_o),
        .ie_clr_o    (ie_clr_o)
    );

    intr_seq_ctx #(.NEST_DEPTH(NEST_DEPTH)) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (go_entry),
        .push_brk_i (go_brk),
        .pop_i      (go_return),
        .pop_reti_i (go_reti),
        .misuse_o   (misuse_o)
    );

endmodule

// File: rtl/intr_seq_chk.sv
// Protocol checker for the sequencer ports; attached by bind below.
// Assumes the memory side keeps mem_ack_i low when no request is open.
module intr_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ack_i,
    input logic          pc_load_o,
    input logic          sp_load_o,
    input logic          psw_load_o,
    input logic          ie_clr_o,
    input logic          misuse_o
);

    // R1: no memory traffic outside an operation.
    assert_req_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R8: an unacknowledged request is held unchanged.
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R4: entry completion loads PC and SP, not the flags.
    assert_entry_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr_o |-> (pc_load_o && sp_load_o && !psw_load_o));

    // R5: return completion loads flags and never clears IE.
    assert_return_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load_o |-> (pc_load_o && sp_load_o && !ie_clr_o));

    // R7: misuse only marks the first read of a return.
    assert_misuse_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        misuse_o |-> (busy_o && mem_req_o && !mem_we_o && !$past(busy_o)));

    // R9: completion lasts one cycle and no strobe re-arms the same cycle.
    assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !busy_o);

endmodule

bind intr_seq_top intr_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .pc_load_o  (pc_load_o),
    .sp_load_o  (sp_load_o),
    .psw_load_o (psw_load_o),
    .ie_clr_o   (ie_clr_o),
    .misuse_o   (misuse_o)
);

// File: tb/intr_seq_top_tb_top.sv
// Scoreboard bench: tasks queue expected bus beats and completions,
// a negedge monitor pops and compares them against the ports.
module intr_seq_top_tb_top;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef struct {
        bit            is_done;
        bit            we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        bit            psw_ld;
        logic [DW-1:0] psw;
        bit            ie_clr;
        bit            misuse;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          brk_i = 1'b0, ack_i = 1'b0, retb_i = 1'b0, reti_i = 1'b0;
    logic [AW-1:0] ack_vec_i = '0, pc_i = '0, sp_i = '0;
    logic [DW-1:0] psw_i = '0;
    logic          mem_req_o, mem_we_o, mem_ack_i;
    logic [AW-1:0] mem_addr_o, pc_new_o, sp_new_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i, psw_new_o;
    logic          busy_o, pc_load_o, sp_load_o, psw_load_o, ie_clr_o, misuse_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   wait_cyc = 0;
    int   wcnt     = 0;
    bit   misuse_seen = 0;
    bit   prev_hold = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] mem [int];
    exp_t q [$];

    always #4 clk = ~clk;

    intr_seq_top #(.AW(AW), .DW(DW), .NEST_DEPTH(2), .BRK_VEC(16'h003E)) dut_i (
        .clk(clk), .rst_n(rst_n), .brk_i(brk_i), .ack_i(ack_i), .ack_vec_i(ack_vec_i),
        .retb_i(retb_i), .reti_i(reti_i), .psw_i(psw_i), .pc_i(pc_i), .sp_i(sp_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o),
        .sp_load_o(sp_load_o), .sp_new_o(sp_new_o), .psw_load_o(psw_load_o),
        .psw_new_o(psw_new_o), .ie_clr_o(ie_clr_o), .misuse_o(misuse_o)
    );

    function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : '0;
    endfunction

    // Memory model: acknowledge after wait_cyc held cycles.
    assign mem_ack_i   = mem_req_o && (wcnt == wait_cyc);
    assign mem_rdata_i = rd(mem_addr_o);

    always @(posedge clk) begin
        if (!rst_n) wcnt <= 0;
        else if (mem_ack_i) begin
            wcnt <= 0;
            if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
        end else if (mem_req_o) wcnt <= wcnt + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_beat(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input string tag);
        exp_t e;
        e = '{default: '0, tag: tag};
        e.we = we; e.addr = a; e.data = d;
        q.push_back(e);
    endtask

    // Expected items for an entry (R2, R3, R4, R7).
    task automatic exp_entry(input logic [AW-1:0] vec, input logic [DW-1:0] psw,
                             input logic [AW-1:0] pc, input logic [AW-1:0] sp);
        exp_t e;
        push_beat(1, sp - 16'd1, psw, "R2");
        push_beat(1, sp - 16'd2, pc[15:8], "R2");
        push_beat(1, sp - 16'd3, pc[7:0], "R2");
        push_beat(0, vec, '0, "R3");
        push_beat(0, vec | 16'd1, '0, "R3");
        e = '{default: '0, tag: "R4"};
        e.is_done = 1; e.pc = {rd(vec | 16'd1), rd(vec)}; e.sp = sp - 16'd3;
        e.ie_clr = 1; e.misuse = 0;
        q.push_back(e);
    endtask

    // Expected items for a return (R5, R6, R7, R11).
    task automatic exp_return(input logic [AW-1:0] sp, input bit mis, input string mtag);
        exp_t e;
        push_beat(0, sp, '0, "R5");
        push_beat(0, sp + 16'd1, '0, "R5");
        push_beat(0, sp + 16'd2, '0, "R5");
        e = '{default: '0, tag: mtag};
        e.is_done = 1; e.pc = {rd(sp + 16'd1), rd(sp)}; e.sp = sp + 16'd3;
        e.psw_ld = 1; e.psw = rd(sp + 16'd2); e.misuse = mis;
        q.push_back(e);
    endtask

    // Drive one strobe set {brk,ack,retb,reti}; optionally disturb while busy.
    task automatic pulse(input logic [3:0] s, input logic [AW-1:0] vec,
                         input logic [DW-1:0] psw, input logic [AW-1:0] pc,
                         input logic [AW-1:0] sp, input bit disturb);
        @(negedge clk);
        {brk_i, ack_i, retb_i, reti_i} = s;
        ack_vec_i = vec; psw_i = psw; pc_i = pc; sp_i = sp;
        @(negedge clk);
        {brk_i, ack_i, retb_i, reti_i} = '0;
        if (disturb) begin
            @(negedge clk);
            {brk_i, ack_i, retb_i, reti_i} = 4'b1111;
            pc_i = 16'hDEAD; psw_i = 8'h5A; sp_i = 16'h1111; ack_vec_i = 16'h0020;
            @(negedge clk);
            {brk_i, ack_i, retb_i, reti_i} = '0;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
        check(!busy_o && !mem_req_o, "R9", "idle after op", {busy_o, mem_req_o}, 0);
        check(q.size() == 0, "R9", "queue drained", q.size(), 0);
    endtask

    // Monitor: compare every beat and completion against the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (misuse_o) misuse_seen = 1;
            if (prev_hold)
                check(mem_req_o && mem_addr_o == prev_addr, "R8", "held request addr",
                      mem_addr_o, prev_addr);
            prev_hold = mem_req_o && !mem_ack_i;
            prev_addr = mem_addr_o;
            if (mem_req_o && mem_ack_i) begin
                if (q.size() == 0 || q[0].is_done)
                    check(0, "R9", "unexpected beat", mem_addr_o, 0);
                else begin
                    e = q.pop_front();
                    check(mem_we_o == e.we && mem_addr_o == e.addr, e.tag, "beat addr/dir",
                          {mem_we_o, mem_addr_o}, {e.we, e.addr});
                    if (e.we)
                        check(mem_wdata_o == e.data, e.tag, "beat data", mem_wdata_o, e.data);
                end
            end
            if (pc_load_o) begin
                if (q.size() == 0 || !q[0].is_done)
                    check(0, "R9", "unexpected completion", pc_new_o, 0);
                else begin
                    e = q.pop_front();
                    check(pc_new_o == e.pc, e.tag, "new pc", pc_new_o, e.pc);
                    check(sp_load_o && sp_new_o == e.sp, e.tag, "new sp", sp_new_o, e.sp);
                    check(ie_clr_o == e.ie_clr && psw_load_o == e.psw_ld, e.tag,
                          "ie_clr/psw_load", {ie_clr_o, psw_load_o}, {e.ie_clr, e.psw_ld});
                    if (e.psw_ld)
                        check(psw_new_o == e.psw, e.tag, "restored psw", psw_new_o, e.psw);
                    check(misuse_seen == e.misuse, "R7", "misuse flag", misuse_seen, e.misuse);
                end
                misuse_seen = 0;
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        mem[16'h0010] = 8'h00; mem[16'h0011] = 8'h30;
        mem[16'h0020] = 8'h40; mem[16'h0021] = 8'h31;
        mem[16'h003E] = 8'h00; mem[16'h003F] = 8'h20;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !mem_req_o && !pc_load_o && !sp_load_o && !psw_load_o
              && !ie_clr_o && !misuse_o, "R1", "reset outputs", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Hardware entry, then return through retb: R2 R3 R4 R6
        wait_cyc = 0;
        exp_entry(16'h0010, 8'h80, 16'h1234, 16'hFE00);
        pulse(4'b0100, 16'h0010, 8'h80, 16'h1234, 16'hFE00, 0);
        exp_return(16'hFDFD, 0, "R6");
        pulse(4'b0010, '0, '0, '0, 16'hFDFD, 0);

        // Break with IE clear (R4), then misused hardware return (R7)
        wait_cyc = 1;
        exp_entry(16'h003E, 8'h02, 16'h0456, 16'hFE00);
        pulse(4'b1000, 16'h0010, 8'h02, 16'h0456, 16'hFE00, 0);
        exp_return(16'hFDFD, 1, "R7");
        pulse(4'b0001, '0, '0, '0, 16'hFDFD, 0);

        // Nested: break then hardware; reti clean, reti misuse (R7, R11)
        wait_cyc = 2;
        exp_entry(16'h003E, 8'h81, 16'h0A00, 16'hFE00);
        pulse(4'b1000, '0, 8'h81, 16'h0A00, 16'hFE00, 0);
        exp_entry(16'h0020, 8'h82, 16'h2002, 16'hFDFD);
        pulse(4'b0100, 16'h0020, 8'h82, 16'h2002, 16'hFDFD, 0);
        exp_return(16'hFDFA, 0, "R11");
        pulse(4'b0001, '0, '0, '0, 16'hFDFA, 0);
        exp_return(16'hFDFD, 1, "R7");
        pulse(4'b0001, '0, '0, '0, 16'hFDFD, 0);

        // Overflow of a depth-2 tracker drops the break context (R11)
        wait_cyc = 0;
        exp_entry(16'h003E, 8'h00, 16'h0100, 16'hFE00);
        pulse(4'b1000, '0, 8'h00, 16'h0100, 16'hFE00, 0);
        exp_entry(16'h0010, 8'h00, 16'h0200, 16'hFDFD);
        pulse(4'b0100, 16'h0010, 8'h00, 16'h0200, 16'hFDFD, 0);
        exp_entry(16'h0020, 8'h00, 16'h0300, 16'hFDFA);
        pulse(4'b0100, 16'h0020, 8'h00, 16'h0300, 16'hFDFA, 0);
        exp_return(16'hFDF7, 0, "R11");
        pulse(4'b0001, '0, '0, '0, 16'hFDF7, 0);
        exp_return(16'hFDFA, 0, "R11");
        pulse(4'b0001, '0, '0, '0, 16'hFDFA, 0);
        exp_return(16'hFDFD, 0, "R11");
        pulse(4'b0001, '0, '0, '0, 16'hFDFD, 0);

        // Strobes and input changes while busy are ignored (R9, R8)
        wait_cyc = 1;
        exp_entry(16'h0010, 8'h84, 16'h7788, 16'hFE00);
        pulse(4'b0100, 16'h0010, 8'h84, 16'h7788, 16'hFE00, 1);
        exp_return(16'hFDFD, 0, "R9");
        pulse(4'b0010, '0, '0, '0, 16'hFDFD, 1);

        // Simultaneous strobes follow the fixed order (R10)
        wait_cyc = 0;
        exp_entry(16'h003E, 8'h11, 16'h0BBB, 16'hFE00);
        pulse(4'b1111, 16'h0010, 8'h11, 16'h0BBB, 16'hFE00, 0);
        exp_return(16'hFDFD, 0, "R10");
        pulse(4'b0011, '0, '0, '0, 16'hFDFD, 0);
        exp_entry(16'h0020, 8'h22, 16'h0CCC, 16'hFE00);
        pulse(4'b0101, 16'h0020, 8'h22, 16'h0CCC, 16'hFE00, 0);
        exp_return(16'hFDFD, 0, "R10");
        pulse(4'b0010, '0, '0, '0, 16'hFDFD, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule